// File: doc/BRIEF.md
# Quadrature Sine/Cosine Synthesizer with Square Reference

This block is a direct digital synthesizer that feeds the reference path of a lock-in measurement. A single phase accumulator advances by a programmable tuning word on every clock. Three outputs are derived from that one phase value, so their frequencies are identical by construction. The first is a one-bit square wave that leaves the chip to modulate an excitation source. The other two are signed sine and cosine samples that stay on chip for demodulation. The output frequency is f_clk * tune_word / 2^32. For example, with a 40 MHz clock and a 32754 Hz target the tuning word is 3516934.

Amplitudes are read from a quarter-wave table computed at elaboration. Quadrant folding mirrors the table address and flips the sign to rebuild the whole wave. Two options, each with its own enable, reduce phase-truncation spurs. Phase dithering adds a pseudo-random offset below the table address before truncation. Linear interpolation blends neighbouring table points using the phase bits below the address. When the clock is not an integer multiple of the output frequency, the square wave keeps its one-clock edge wander; nothing smooths it.

Top module: `qdds_ref`

## Requirements
- R1: The 32-bit phase accumulator adds tune_word on every clock edge, modulo 2^32, unless phase_clr is high.
- R2: When phase_clr is high at a clock edge, the accumulator becomes zero at that edge. The outputs for phase 0 appear three edges later.
- R3: sq_out equals bit 31 of the accumulator value from three edges earlier. It is therefore high during the second half of each period.
- R4: With both options off, the 12-bit table index is phase bits 31:20. sin_out is then within 2 LSB of 32767*sin(2*pi*(index+0.5)/4096).
- R5: cos_out follows the R4 and R6 rules applied to the phase plus 2^30, a quarter turn ahead of the sine.
- R6: With interp_en high, the fraction is phase bits 19:12 (8 bits). Both samples are within 2 LSB of 32767*sin(2*pi*(index+0.5+fraction/256)/4096).
- R7: With dither_en high, a 16-bit maximal-length LFSR value shifted left by 4 (bits 19:4) is added to the phase before truncation. The used index is therefore the undithered index or the next one. sq_out is unaffected. With dither_en low, no offset is added.
- R8: Each high or low run of sq_out lasts floor or ceil of 2^31/tune_word clocks. When that ratio is an integer, every run has exactly that length.
- R9: While reset is held, sq_out, sin_out and cos_out are all zero.
- R10: Sine and cosine never take the value -32768. With both options off, sq_out is high exactly when sin_out is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tune_word | input | 32 | Phase increment added each clock |
| phase_clr | input | 1 | Synchronous clear of the accumulator |
| dither_en | input | 1 | Enables phase dithering before truncation |
| interp_en | input | 1 | Enables linear interpolation between table points |
| sq_out | output | 1 | Square reference, accumulator MSB after three cycles |
| sin_out | output | 16 | Signed sine sample |
| cos_out | output | 16 | Signed cosine sample |

## Verification
The sign assertion between sq_out and sin_out assumes that dither_en has been low for the three cycles feeding the current output and that interp_en has been low for two cycles. The stimulus therefore changes the option enables only together with a phase clear, and holds them steady across each sweep. The accumulator step assertion assumes that tune_word is steady between edges. The bench changes it only at the falling clock edge. The sweeps use a one-index-per-clock tuning word, an odd word that walks every fraction value, a dithered word, and two square-wave cases: one whose half period divides evenly and one whose half period does not.

// File: rtl/qdds_pkg.sv
package qdds_pkg;
  typedef enum logic [1:0] {
    QD_RISE     = 2'd0,
    QD_FALL     = 2'd1,
    QD_NEG_FALL = 2'd2,
    QD_NEG_RISE = 2'd3
  } quadrant_e;
endpackage

// File: rtl/qdds_phase_acc.sv
module qdds_phase_acc #(
  parameter int ACC_W  = 32,
  parameter int LOW_W  = 20,
  parameter int LFSR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] tune,
  input  logic             clr,
  input  logic             dither_en,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] phase_o
);
  localparam int SH = LOW_W - LFSR_W;

  logic [ACC_W-1:0]  acc_q, acc_n;
  logic [LFSR_W-1:0] lfsr_q, lfsr_n;
  logic [ACC_W-1:0]  dith_val;

  always_comb begin
    acc_n  = clr ? '0 : acc_q + tune;
    lfsr_n = {lfsr_q[LFSR_W-2:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      lfsr_q <= {{(LFSR_W-1){1'b0}}, 1'b1};
    end else begin
      acc_q  <= acc_n;
      lfsr_q <= lfsr_n;
    end
  end

  always_comb begin
    dith_val = '0;
    if (dither_en) dith_val = {{(ACC_W-LFSR_W){1'b0}}, lfsr_q} << SH;
  end

  assign acc_o   = acc_q;
  assign phase_o = acc_q + dith_val;
endmodule

// File: rtl/qdds_quarter_rom.sv
module qdds_quarter_rom #(
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 16,
  parameter int NRD    = 4
) (
  input  logic [NRD-1:0][ADDR_W-1:0] rd_addr,
  output logic [NRD-1:0][AMP_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [AMP_W-1:0] table_w [DEPTH];

  function automatic logic [AMP_W-1:0] quarter_entry(input int i);
    real ang;
    real peak;
    peak = $itor((1 << (AMP_W-1)) - 1);
    ang  = 1.5707963267948966 * ($itor(i) + 0.5) / $itor(DEPTH);
    return AMP_W'($rtoi(peak * $sin(ang) + 0.5));
  endfunction

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tab
    assign table_w[gi] = quarter_entry(gi);
  end

  for (genvar gr = 0; gr < NRD; gr++) begin : g_rd
    assign rd_data[gr] = table_w[rd_addr[gr]];
  end
endmodule

// File: rtl/qdds_quad_fold.sv
module qdds_quad_fold
  import qdds_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W+1:0] idx,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              negate
);
  quadrant_e quad;

  always_comb begin
    quad = quadrant_e'(idx[ADDR_W+1:ADDR_W]);
    unique case (quad)
      QD_RISE:     begin rom_addr = idx[ADDR_W-1:0];  negate = 1'b0; end
      QD_FALL:     begin rom_addr = ~idx[ADDR_W-1:0]; negate = 1'b0; end
      QD_NEG_FALL: begin rom_addr = idx[ADDR_W-1:0];  negate = 1'b1; end
      default:     begin rom_addr = ~idx[ADDR_W-1:0]; negate = 1'b1; end
    endcase
  end
endmodule

// File: rtl/qdds_interp.sv
module qdds_interp #(
  parameter int AMP_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic [AMP_W-1:0]  s0,
  input  logic [AMP_W-1:0]  s1,
  input  logic [FRAC_W-1:0] frac,
  input  logic              en,
  output logic [AMP_W-1:0]  y
);
  localparam int PW = AMP_W + FRAC_W + 2;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC_W-1);

  logic signed [AMP_W:0]  diff;
  logic signed [PW-1:0]   prod;
  logic signed [PW-1:0]   step_w;

  always_comb begin
    diff   = $signed({s1[AMP_W-1], s1}) - $signed({s0[AMP_W-1], s0});
    prod   = diff * $signed({1'b0, frac});
    step_w = (prod + HALF) >>> FRAC_W;
    y      = en ? s0 + step_w[AMP_W-1:0] : s0;
  end
endmodule

// File: rtl/qdds_ref.sv
module qdds_ref #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 16,
  parameter int FRAC_W = 8,
  parameter int LFSR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] tune_word,
  input  logic             phase_clr,
  input  logic             dither_en,
  input  logic             interp_en,
  output logic             sq_out,
  output logic [AMP_W-1:0] sin_out,
  output logic [AMP_W-1:0] cos_out
);
  localparam int IDX_W = ADDR_W + 2;
  localparam int LOW_W = ACC_W - IDX_W;
  localparam int NL    = 4;
  localparam int NCH   = 2;
  localparam logic [IDX_W-1:0] QTR = IDX_W'(1) << ADDR_W;

  logic [1:0] rsync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  logic [ACC_W-1:0] acc_q, ph_dith;

  qdds_phase_acc #(.ACC_W(ACC_W), .LOW_W(LOW_W), .LFSR_W(LFSR_W)) u_acc (
    .clk(clk), .rst_n(rst_q_n), .tune(tune_word), .clr(phase_clr),
    .dither_en(dither_en), .acc_o(acc_q), .phase_o(ph_dith)
  );

  logic phase_unused_bits;
  assign phase_unused_bits = ^ph_dith[LOW_W-FRAC_W-1:0];

  // stage 1: truncated phase
  logic [IDX_W-1:0]  s1_idx_q, s1_idx_n;
  logic [FRAC_W-1:0] s1_frac_q, s1_frac_n;
  logic              s1_sq_q, s1_sq_n;

  always_comb begin
    s1_idx_n  = ph_dith[ACC_W-1 -: IDX_W];
    s1_frac_n = ph_dith[LOW_W-1 -: FRAC_W];
    s1_sq_n   = acc_q[ACC_W-1];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      s1_idx_q <= '0; s1_frac_q <= '0; s1_sq_q <= 1'b0;
    end else begin
      s1_idx_q <= s1_idx_n; s1_frac_q <= s1_frac_n; s1_sq_q <= s1_sq_n;
    end
  end

  // lanes: sine, sine next, cosine, cosine next
  logic [NL-1:0][IDX_W-1:0]  lane_idx;
  logic [NL-1:0][ADDR_W-1:0] rom_addr;
  logic [NL-1:0][AMP_W-1:0]  rom_mag;
  logic [NL-1:0]             lane_neg;
  logic [NL-1:0][AMP_W-1:0]  s2_smp_q, s2_smp_n;
  logic [FRAC_W-1:0]         s2_frac_q;
  logic                      s2_sq_q;

  always_comb begin
    lane_idx[0] = s1_idx_q;
    lane_idx[1] = s1_idx_q + IDX_W'(1);
    lane_idx[2] = s1_idx_q + QTR;
    lane_idx[3] = s1_idx_q + QTR + IDX_W'(1);
  end

  for (genvar gl = 0; gl < NL; gl++) begin : g_lane
    qdds_quad_fold #(.ADDR_W(ADDR_W)) u_fold (
      .idx(lane_idx[gl]), .rom_addr(rom_addr[gl]), .negate(lane_neg[gl])
    );
    assign s2_smp_n[gl] = lane_neg[gl] ? AMP_W'(-$signed(rom_mag[gl])) : rom_mag[gl];
  end

  qdds_quarter_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W), .NRD(NL)) u_rom (
    .rd_addr(rom_addr), .rd_data(rom_mag)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      s2_smp_q <= '0; s2_frac_q <= '0; s2_sq_q <= 1'b0;
    end else begin
      s2_smp_q <= s2_smp_n; s2_frac_q <= s1_frac_q; s2_sq_q <= s1_sq_q;
    end
  end

  // stage 3: interpolation and output registers
  logic [NCH-1:0][AMP_W-1:0] ch_n, ch_q;
  logic                      sq_q;

  for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
    qdds_interp #(.AMP_W(AMP_W), .FRAC_W(FRAC_W)) u_interp (
      .s0(s2_smp_q[2*gc]), .s1(s2_smp_q[2*gc+1]), .frac(s2_frac_q),
      .en(interp_en), .y(ch_n[gc])
    );
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ch_q <= '0; sq_q <= 1'b0;
    end else begin
      ch_q <= ch_n; sq_q <= s2_sq_q;
    end
  end

  assign sq_out  = sq_q;
  assign sin_out = ch_q[0];
  assign cos_out = ch_q[1];
endmodule

// File: rtl/qdds_ref_chk.sv
module qdds_ref_chk #(
  parameter int ACC_W = 32,
  parameter int AMP_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] tune,
  input logic             clr,
  input logic             dither_en,
  input logic             interp_en,
  input logic             sq_out,
  input logic [AMP_W-1:0] sin_out,
  input logic [AMP_W-1:0] cos_out
);
  localparam logic [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

  a_r1_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> acc == $past(acc) + $past(tune));

  a_r2_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc == '0);

  a_r3_sq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    sq_out == $past(acc[ACC_W-1], 3));

  a_r10_range: assert property (@(posedge clk) disable iff (!rst_n)
    sin_out != MOST_NEG && cos_out != MOST_NEG);

  a_r10_sq_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (!dither_en && !$past(dither_en) && !$past(dither_en, 2) && !$past(dither_en, 3)
     && !interp_en && !$past(interp_en) && !$past(interp_en, 2))
    |-> sq_out == sin_out[AMP_W-1]);
endmodule

bind qdds_ref qdds_ref_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .acc(acc_q), .tune(tune_word), .clr(phase_clr),
  .dither_en(dither_en), .interp_en(interp_en), .sq_out(sq_out),
  .sin_out(sin_out), .cos_out(cos_out)
);

// File: tb/sim_qdds_ref.sv
module sim_qdds_ref;
  logic        clk;
  logic        rst_n;
  logic [31:0] tune_word;
  logic        phase_clr, dither_en, interp_en;
  logic        sq_out;
  logic [15:0] sin_out, cos_out;

  int checks = 0;
  int failures = 0;
  localparam real TWO_PI = 6.283185307179586;

  qdds_ref u0 (
    .clk(clk), .rst_n(rst_n), .tune_word(tune_word), .phase_clr(phase_clr),
    .dither_en(dither_en), .interp_en(interp_en), .sq_out(sq_out),
    .sin_out(sin_out), .cos_out(cos_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic real mdl(input logic [31:0] ph, input bit itp);
    real pos;
    pos = $itor(ph[31:20]) + 0.5;
    if (itp) pos = pos + $itor(ph[19:12]) / 256.0;
    return 32767.0 * $sin(TWO_PI * pos / 4096.0);
  endfunction

  function automatic bit near(input logic [15:0] v, input real e);
    real d;
    d = $itor($signed(v)) - e;
    return (d <= 2.0) && (d >= -2.0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [31:0] tw, input bit dith, input bit itp);
    @(negedge clk);
    tune_word = tw; dither_en = dith; interp_en = itp; phase_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    phase_clr = 1'b0;
  endtask

  // sweep: sample m (after edge m following the clear) reflects phase (m-3)*tw
  task automatic sweep(input logic [31:0] tw, input bit dith, input bit itp, input int n);
    logic [31:0] p;
    int spread;
    p = '0;
    spread = 0;
    start(tw, dith, itp);
    for (int m = 1; m <= n; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (m >= 3) begin
        chk(sq_out == p[31], "R3 square", int'(sq_out), int'(p[31]));
        if (m == 3)
          chk(near(sin_out, mdl(32'd0, itp)) && !sq_out, "R2 clear to phase 0",
              int'($signed(sin_out)), $rtoi(mdl(32'd0, itp)));
        if (!dith) begin
          chk(near(sin_out, mdl(p, itp)), itp ? "R6 interp sine" : "R4 sine",
              int'($signed(sin_out)), $rtoi(mdl(p, itp)));
          chk(near(cos_out, mdl(p + 32'h4000_0000, itp)), "R5 cosine",
              int'($signed(cos_out)), $rtoi(mdl(p + 32'h4000_0000, itp)));
          if (!itp)
            chk(sq_out == sin_out[15], "R10 sign vs square", int'(sq_out), int'(sin_out[15]));
        end else begin
          chk(near(sin_out, mdl(p, 0)) || near(sin_out, mdl(p + 32'h0010_0000, 0)),
              "R7 dither index", int'($signed(sin_out)), $rtoi(mdl(p, 0)));
          chk(near(cos_out, mdl(p + 32'h4000_0000, 0)) ||
              near(cos_out, mdl(p + 32'h4010_0000, 0)),
              "R7 dither cosine", int'($signed(cos_out)), $rtoi(mdl(p + 32'h4000_0000, 0)));
          if (!near(sin_out, mdl(p, 0))) spread++;
        end
        chk(sin_out != 16'h8000 && cos_out != 16'h8000, "R10 range",
            int'($signed(sin_out)), 0);
        p = p + tw;
      end
    end
    if (dith) chk(spread > 0, "R7 dither active", spread, 1);
  endtask

  task automatic runs(input logic [31:0] tw, input int n, input int lo, input int hi);
    logic prev;
    int len, seen_lo, seen_hi, started;
    len = 0; seen_lo = 0; seen_hi = 0; started = 0;
    start(tw, 1'b0, 1'b0);
    prev = sq_out;
    for (int m = 1; m <= n; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (m >= 3) begin
        if (sq_out != prev) begin
          if (started != 0) begin
            chk(len == lo || len == hi, "R8 run length", len, lo);
            if (len == lo) seen_lo++;
            if (len == hi) seen_hi++;
          end
          started = 1;
          len = 1;
        end else begin
          len++;
        end
        prev = sq_out;
      end
    end
    chk(seen_lo > 0, "R8 short runs seen", seen_lo, 1);
    if (hi != lo) chk(seen_hi > 0, "R8 long runs seen", seen_hi, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tune_word = 32'h0010_0000;
    phase_clr = 1'b0; dither_en = 1'b0; interp_en = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(sq_out == 1'b0, "R9 reset square", int'(sq_out), 0);
    chk(sin_out == 16'd0, "R9 reset sine", int'($signed(sin_out)), 0);
    chk(cos_out == 16'd0, "R9 reset cosine", int'($signed(cos_out)), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    sweep(32'h0010_0000, 1'b0, 1'b0, 4100);   // every index once, R1 R4
    sweep(32'h000F_3A57, 1'b0, 1'b0, 1500);   // odd word, R1 R4 R5
    sweep(32'h000F_3A57, 1'b0, 1'b1, 4100);   // all fractions, R6
    sweep(32'h0010_0123, 1'b1, 1'b0, 3000);   // R7
    sweep(32'h0123_4567, 1'b0, 1'b1, 800);    // fast word with interpolation
    runs(32'h0400_0000, 400, 32, 32);         // even half period, R8
    runs(32'd3516934, 6500, 610, 611);        // 32754 Hz at 40 MHz, R8

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule